// File: doc/BRIEF.md
# Serial Bus Slave Front End for a Clock/Calendar Register Space

This block is the target side of a two-wire serial bus (I2C-style, 7-bit addressing, no clock stretching). It oversamples the SCL and SDA lines on a fast system clock and detects START and STOP conditions. It answers one fixed device address and gives access to a 64-byte space. The first seven locations hold the timekeeping counters (seconds through year). Location 7 is the control byte, and locations 8 to 63 are general storage. The 64 bytes live in a register file inside the block.

A master writes by sending the device address with the direction bit clear. The next byte loads a 6-bit location pointer, and each byte after that is stored at the pointer, which then advances. A master reads by sending the device address with the direction bit set. It may first load the pointer in a write phase followed by a repeated START. It may also skip that phase and continue from wherever the pointer was left. The pointer advances only when the master acknowledges a byte.

A power-fail input forces the block idle, clears the pointer and makes it deaf to the bus until the input drops. A read-active output tells the timekeeping core that a read is in progress over the counter locations, so the core can hold off its update. SDA is open drain: the block only ever pulls the line low.

Top module: `rtc_bus_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits are 1101000: 0xD0 selects a write and 0xD1 selects a read. The acknowledge is an SDA low for the ninth clock.
- R2: START is SDA falling with SCL high, and STOP is SDA rising with SCL high. The block changes its own SDA drive only while SCL is low.
- R3: In a write, the byte after the address loads the pointer. The block acknowledges the address byte, the pointer byte and every data byte.
- R4: Each written data byte is stored at the pointer, and the pointer then advances by one.
- R5: A read returns the byte at the pointer, most significant bit first. The pointer advances only when the master acknowledges that byte.
- R6: After a master NACK the block releases SDA, sends no further data and leaves the pointer unchanged.
- R7: A read with no pointer write before it starts at the pointer value left by the previous transaction.
- R8: While pwr_fail is high, any transfer is abandoned, SDA is released and the pointer is set to 0. The bus is ignored, with nothing acknowledged and nothing stored. After pwr_fail drops, the block waits for a new START.
- R9: The pointer wraps from 63 to 0, for writes and for reads.
- R10: After a non-matching address byte the block gives no acknowledge. It ignores every later byte until the next START, and the pointer and storage are unchanged.
- R11: read_active is high during a read transaction while the pointer is within 0–6. It is low when the pointer is 7 or higher, in write transactions, and after STOP.
- R12: After reset, SDA is released, read_active is low, the pointer is 0 and every storage byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_fail | input | 1 | High while supply is out of tolerance; aborts and deafens the block |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| read_active | output | 1 | Read transaction in progress over counter locations 0–6 |

## Verification
The hardest case to reach from the pins is a power-fail that lands mid-transaction. The pointer has already been loaded, and the master keeps clocking as if nothing happened. The bench raises pwr_fail between bytes of a live write and shifts a full data byte while it is high. It then drops pwr_fail and shifts another byte with no START. A current-location read must then return location 0, and a random read must show the old byte untouched. A second subtle point is that a NACK does not advance the pointer. This is reached by a three-byte burst read across the 63-to-0 wrap, followed by a read with no pointer write.

// File: rtl/rtc_bus_pkg.sv
package rtc_bus_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,      // waiting for START
        ST_DEVADDR,   // shifting in device address + direction
        ST_DEVACK,    // driving ack for the device address
        ST_WORDADDR,  // shifting in pointer byte
        ST_WORDACK,   // driving ack for the pointer byte
        ST_WRDATA,    // shifting in a data byte
        ST_WRACK,     // driving ack for a data byte
        ST_RDDATA,    // shifting out a data byte
        ST_RDACK      // sampling the master's ack
    } bus_state_t;

endpackage

// File: rtl/rtc_bus_cond.sv
module rtc_bus_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[STAGES-2:0], sda_i};
            scl_q     <= scl_chain[STAGES-1];
            sda_q     <= sda_chain[STAGES-1];
        end
    end

    assign scl_s     = scl_chain[STAGES-1];
    assign sda_s     = sda_chain[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/rtc_bus_regfile.sv
module rtc_bus_regfile #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/rtc_bus_slave.sv
module rtc_bus_slave
    import rtc_bus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1101000,
    parameter int         ADDR_W      = 6,
    parameter int         DATA_W      = 8,
    parameter int         CLK_REGS    = 7,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_fail,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic read_active
);

    localparam int                CNT_W     = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0]  BITS_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0]  BITS_LAST = CNT_W'(DATA_W - 1);
    localparam logic [ADDR_W-1:0] CLK_TOP   = ADDR_W'(CLK_REGS);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    rtc_bus_cond #(.STAGES(SYNC_STAGES)) cond_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    bus_state_t        state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] tx;
    logic [ADDR_W-1:0] ptr;
    logic              rd_txn;
    logic              m_ack;
    logic              byte_done;
    logic              addr_hit;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rdata;

    assign byte_done = scl_fall && (bit_cnt == BITS_FULL);
    assign addr_hit  = (shreg[DATA_W-1:1] == DEV_ADDR);
    assign mem_we    = !pwr_fail && (state == ST_WRDATA) && byte_done;

    rtc_bus_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (ptr),
        .wdata (shreg),
        .rdata (mem_rdata)
    );

    // transitions
    always_comb begin
        state_nx = state;
        if (pwr_fail) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_DEVADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_DEVADDR:  if (byte_done) state_nx = addr_hit ? ST_DEVACK : ST_IDLE;
                ST_DEVACK:   if (scl_fall)  state_nx = shreg[0] ? ST_RDDATA : ST_WORDADDR;
                ST_WORDADDR: if (byte_done) state_nx = ST_WORDACK;
                ST_WORDACK:  if (scl_fall)  state_nx = ST_WRDATA;
                ST_WRDATA:   if (byte_done) state_nx = ST_WRACK;
                ST_WRACK:    if (scl_fall)  state_nx = ST_WRDATA;
                ST_RDDATA:   if (scl_fall && bit_cnt == BITS_LAST) state_nx = ST_RDACK;
                ST_RDACK:    if (scl_fall)  state_nx = m_ack ? ST_RDDATA : ST_IDLE;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            tx      <= '0;
            ptr     <= '0;
            rd_txn  <= 1'b0;
            m_ack   <= 1'b0;
        end else if (pwr_fail) begin
            bit_cnt <= '0;
            ptr     <= '0;
            rd_txn  <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
            rd_txn  <= 1'b0;
        end else begin
            case (state)
                ST_DEVADDR, ST_WORDADDR, ST_WRDATA: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[DATA_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_done) begin
                        bit_cnt <= '0;
                        if (state == ST_DEVADDR && addr_hit && shreg[0]) rd_txn <= 1'b1;
                        if (state == ST_WORDADDR) ptr <= shreg[ADDR_W-1:0];
                        if (state == ST_WRDATA)   ptr <= ptr + 1'b1;
                    end
                end
                ST_DEVACK: begin
                    if (scl_fall && shreg[0]) tx <= mem_rdata;
                end
                ST_RDDATA: begin
                    if (scl_fall) begin
                        tx      <= {tx[DATA_W-2:0], 1'b0};
                        bit_cnt <= (bit_cnt == BITS_LAST) ? '0 : bit_cnt + 1'b1;
                    end
                end
                ST_RDACK: begin
                    if (scl_rise) begin
                        m_ack <= ~sda_s;
                        if (!sda_s) ptr <= ptr + 1'b1;
                    end else if (scl_fall && m_ack) begin
                        tx <= mem_rdata;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_DEVACK, ST_WORDACK, ST_WRACK: sda_oe = 1'b1;
            ST_RDDATA:                       sda_oe = ~tx[DATA_W-1];
            default:                         sda_oe = 1'b0;
        endcase
        read_active = rd_txn && (ptr < CLK_TOP);
    end

endmodule

// File: rtl/rtc_bus_slave_chk.sv
module rtc_bus_slave_chk
    import rtc_bus_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_fail,
    input logic              scl_s,
    input logic              sda_oe,
    input logic              read_active,
    input logic [ADDR_W-1:0] ptr,
    input bus_state_t        state
);

    AST_PF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> !sda_oe); // R8

    AST_PF_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (ptr == '0)); // R8

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s); // R2

    AST_RD_NOT_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        read_active |-> !(state inside {ST_WORDADDR, ST_WORDACK, ST_WRDATA, ST_WRACK})); // R11

    AST_IDLE_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !pwr_fail) |=> $stable(ptr)); // R10

endmodule

bind rtc_bus_slave rtc_bus_slave_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_fail    (pwr_fail),
    .scl_s       (scl_s),
    .sda_oe      (sda_oe),
    .read_active (read_active),
    .ptr         (ptr),
    .state       (state)
);

// File: tb/rtc_bus_slave_tb.sv
module rtc_bus_slave_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;       // system cycles per quarter bus bit
    localparam int WATCHDOG   = 150000;
    localparam int NVEC       = 8;
    // {location[5:0], data[7:0]}
    localparam logic [13:0] WR_VEC [NVEC] = '{
        {6'd0,  8'h59}, {6'd5,  8'h17}, {6'd7,  8'h83}, {6'd8,  8'h3C},
        {6'd30, 8'hE7}, {6'd47, 8'h01}, {6'd62, 8'h7E}, {6'd63, 8'hFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_fail = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, read_active;
    wire  sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int fails = 0;
    int r2_viol = 0;
    logic oe_prev = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_bus_slave dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_fail    (pwr_fail),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .read_active (read_active)
    );

    // R2: the slave's drive must not move while SCL is high
    always @(negedge clk) begin
        if (rst_n && scl_m && (sda_oe !== oe_prev)) r2_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic clk_bit(input logic b, output logic smp);
        sda_m = b;    wq();
        scl_m = 1'b1; wq();
        smp = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(~give_ack, s);
    endtask

    task automatic write_loc(input logic [5:0] a, input logic [7:0] d, input string req);
        logic k0, k1, k2;
        bus_start();
        send_byte(8'hD0, k0);
        send_byte({2'b00, a}, k1);
        send_byte(d, k2);
        bus_stop();
        chk(req, {5'd0, k0, k1, k2}, 8'h07);
    endtask

    task automatic read_loc(input logic [5:0] a, output logic [7:0] d);
        logic k;
        bus_start();
        send_byte(8'hD0, k);
        send_byte({2'b00, a}, k);
        bus_start();
        send_byte(8'hD1, k);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic read_cur(output logic [7:0] d);
        logic k;
        bus_start();
        send_byte(8'hD1, k);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end

    initial begin
        logic [7:0] d;
        logic       k;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R12 reset state
        chk("R12 sda_oe after reset", {7'd0, sda_oe}, 8'h00);
        chk("R12 read_active after reset", {7'd0, read_active}, 8'h00);
        read_cur(d);
        chk("R12 R7 location 0 after reset", d, 8'h00);

        // vector table: write then random read back (R1 R3 R4 R5)
        for (int v = 0; v < NVEC; v++) begin
            write_loc(WR_VEC[v][13:8], WR_VEC[v][7:0], "R1 R3 acks on write");
            read_loc(WR_VEC[v][13:8], d);
            chk("R4 R5 readback", d, WR_VEC[v][7:0]);
        end

        // burst write across the wrap (R4 R9)
        bus_start();
        send_byte(8'hD0, k); chk("R1 write address ack", {7'd0, k}, 8'h01);
        send_byte(8'd62, k); chk("R3 pointer ack", {7'd0, k}, 8'h01);
        send_byte(8'hA1, k); chk("R3 data ack 62", {7'd0, k}, 8'h01);
        send_byte(8'hB2, k); chk("R3 data ack 63", {7'd0, k}, 8'h01);
        send_byte(8'hC3, k); chk("R9 data ack wrapped", {7'd0, k}, 8'h01);
        bus_stop();

        // burst read across the wrap (R5 R6 R9)
        bus_start();
        send_byte(8'hD0, k);
        send_byte(8'd62, k);
        bus_start();
        send_byte(8'hD1, k); chk("R1 read address ack", {7'd0, k}, 8'h01);
        recv_byte(1'b1, d); chk("R5 burst byte 62", d, 8'hA1);
        recv_byte(1'b1, d); chk("R5 burst byte 63", d, 8'hB2);
        recv_byte(1'b0, d); chk("R9 burst byte wrapped to 0", d, 8'hC3);
        repeat (4) @(negedge clk);
        chk("R6 SDA released after NACK", {7'd0, sda_oe}, 8'h00);
        bus_stop();

        // R7 read from stored pointer; NACK left pointer at 0 (R6)
        read_cur(d);
        chk("R7 R6 current read after NACK", d, 8'hC3);

        // R11 read_active
        bus_start();
        send_byte(8'hD0, k);
        send_byte(8'd3, k);
        chk("R11 low in write transaction", {7'd0, read_active}, 8'h00);
        bus_start();
        send_byte(8'hD1, k);
        chk("R11 high reading location 3", {7'd0, read_active}, 8'h01);
        recv_byte(1'b0, d);
        chk("R11 held until STOP", {7'd0, read_active}, 8'h01);
        bus_stop();
        repeat (4) @(negedge clk);
        chk("R11 dropped at STOP", {7'd0, read_active}, 8'h00);
        bus_start();
        send_byte(8'hD0, k);
        send_byte(8'd6, k);
        bus_start();
        send_byte(8'hD1, k);
        chk("R11 high at location 6", {7'd0, read_active}, 8'h01);
        recv_byte(1'b1, d);
        chk("R11 low once pointer reaches 7", {7'd0, read_active}, 8'h00);
        recv_byte(1'b0, d);
        chk("R5 byte at location 7", d, 8'h83);
        bus_stop();

        // R10 wrong address, then bytes without START
        bus_start();
        send_byte(8'hA0, k); chk("R10 no ack on foreign address", {7'd0, k}, 8'h00);
        send_byte(8'hD0, k); chk("R10 no ack without START", {7'd0, k}, 8'h00);
        send_byte(8'h05, k); chk("R10 no ack on later byte", {7'd0, k}, 8'h00);
        bus_stop();
        read_cur(d);
        chk("R10 pointer untouched", d, 8'h83);

        // R8 power fail mid-transfer
        write_loc(6'd20, 8'h5A, "R3 acks before power fail");
        bus_start();
        send_byte(8'hD0, k);
        send_byte(8'd20, k);
        pwr_fail = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 SDA released on power fail", {7'd0, sda_oe}, 8'h00);
        send_byte(8'h11, k); chk("R8 no ack while power failed", {7'd0, k}, 8'h00);
        bus_stop();
        bus_start();
        send_byte(8'hD0, k); chk("R8 address ignored while power failed", {7'd0, k}, 8'h00);
        bus_stop();
        pwr_fail = 1'b0;
        repeat (3) @(negedge clk);
        send_byte(8'h22, k); chk("R8 no ack before new START", {7'd0, k}, 8'h00);
        bus_stop();
        read_cur(d);
        chk("R8 pointer cleared to 0", d, 8'hC3);
        read_loc(6'd20, d);
        chk("R8 location 20 not overwritten", d, 8'h5A);

        chk("R2 SDA drive changes while SCL high", r2_viol[7:0], 8'h00);
        report();
    end

endmodule